// File: doc/BRIEF.md
# Multi-Port Oldest-First Issue Scheduler

This block is a unified reservation station for an out-of-order core. Each entry holds a waiting micro-op: an identifier the rest of the pipeline uses to find its payload, a readiness flag and a result tag for each source operand, and the set of execution ports that can run it. The set of ports is derived from a small class code supplied at insertion. Each cycle, result tags broadcast by the execution units mark matching sources as ready. Independently of that, every port picks the oldest entry that is fully ready and allowed on that port, provided the unit behind the port is not busy.

Ten ports are arbitrated in a fixed order, from port 0 up to port 9. An entry granted to one port is hidden from every later port in the same cycle, so no micro-op is ever issued twice. Relative age is kept in an age matrix that is updated at insertion, so selection does not depend on slot position. Insertion takes one micro-op per cycle and stalls while every slot is occupied. Operand values and the execution units themselves live outside the block.

Top module: `issue_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no port issues and `ins_ready` is high.
- R2: The class code selects the allowed ports: 0 integer arithmetic uses ports 0, 1, 5 and 6; 1 branch uses ports 0 and 6; 2 divide uses port 0 only; 3 load address uses ports 2 and 3; 4 store address uses ports 7 and 8; 5 store data uses ports 4 and 9. Codes 6 and 7 are treated as integer arithmetic.
- R3: An entry issues only when both sources are ready. A broadcast whose tag matches a waiting source makes that source ready, and the entry becomes eligible in the cycle after the broadcast, not in the broadcast cycle.
- R4: A source whose tag matches a broadcast in the same cycle the micro-op is inserted is stored as ready.
- R5: A port whose busy input is high issues nothing in that cycle. An entry that could use it may issue on another allowed port that is free.
- R6: On each port, the issued entry is the oldest of the ready entries allowed on that port and not taken by a lower-numbered port. Age is insertion order.
- R7: Ports are served in ascending order, and an entry is granted to at most one port per cycle.
- R8: An issued entry leaves the scheduler at the end of its issue cycle, and up to ten entries can issue in one cycle.
- R9: When all DEPTH slots are valid, `ins_ready` is low and an insert request is dropped without effect.
- R10: A micro-op inserted with both sources ready is eligible in the cycle after its insertion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | A free slot exists, so the insert is accepted |
| ins_class | input | 3 | Class code that selects the allowed ports |
| ins_src_tag | input | NSRC*TAG_W | Source result tags, source 0 in the low bits |
| ins_src_rdy | input | NSRC | Per-source readiness at insertion |
| ins_id | input | ID_W | Micro-op identifier returned at issue |
| wb_valid | input | WB_LANES | Per-lane result broadcast valid |
| wb_tag | input | WB_LANES*TAG_W | Per-lane broadcast result tag |
| port_busy | input | 10 | Per-port busy of the unit behind the port |
| iss_valid | output | 10 | Per-port issue valid |
| iss_id | output | 10*ID_W | Per-port issued identifier, port 0 in the low bits |

## Verification
A corrupted age relation shows up directly as the wrong identifier on a port in the first cycle where two competing entries are both ready, so the bench compares every port's identifier against a sequence-numbered model on every cycle. A lost wakeup shows as an entry that never issues, which the final drain catches. A wakeup that lands a cycle early shows as an issue in the broadcast cycle itself. A missed removal appears one cycle later as the same identifier issued a second time. A wrong fullness state appears at once on `ins_ready`, or within a cycle as an accepted insert that should have been dropped.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int NUM_PORTS = 10;

    typedef enum logic [2:0] {
        UC_INT   = 3'd0,
        UC_BRCH  = 3'd1,
        UC_DIV   = 3'd2,
        UC_LDA   = 3'd3,
        UC_STA   = 3'd4,
        UC_STD   = 3'd5,
        UC_RSV6  = 3'd6,
        UC_RSV7  = 3'd7
    } uop_class_e;

    typedef logic [NUM_PORTS-1:0] port_mask_t;

    // Bit p set means port p may run the micro-op.
    function automatic port_mask_t class_ports(input uop_class_e c);
        port_mask_t m;
        case (c)
            UC_BRCH: m = 10'b00_0100_0001;
            UC_DIV:  m = 10'b00_0000_0001;
            UC_LDA:  m = 10'b00_0000_1100;
            UC_STA:  m = 10'b01_1000_0000;
            UC_STD:  m = 10'b10_0001_0000;
            default: m = 10'b00_0110_0011;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sched_entry_array.sv
module sched_entry_array
    import sched_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int TAG_W    = 6,
    parameter int ID_W     = 8,
    parameter int NSRC     = 2,
    parameter int WB_LANES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DEPTH-1:0]          alloc_oh,
    input  logic [DEPTH-1:0]          retire,
    input  port_mask_t                ins_mask,
    input  logic [NSRC*TAG_W-1:0]     ins_tag,
    input  logic [NSRC-1:0]           ins_rdy,
    input  logic [ID_W-1:0]           ins_id,
    input  logic [WB_LANES-1:0]       wb_valid,
    input  logic [WB_LANES*TAG_W-1:0] wb_tag,
    output logic [DEPTH-1:0]          valid_o,
    output logic [DEPTH-1:0]          ready_o,
    output port_mask_t                mask_o [DEPTH],
    output logic [ID_W-1:0]           id_o   [DEPTH]
);

    function automatic logic tag_seen(input logic [TAG_W-1:0] t,
                                      input logic [WB_LANES-1:0] v,
                                      input logic [WB_LANES*TAG_W-1:0] tags);
        logic hit;
        hit = 1'b0;
        for (int l = 0; l < WB_LANES; l++) begin
            if (v[l] && tags[l*TAG_W +: TAG_W] == t) hit = 1'b1;
        end
        return hit;
    endfunction

    logic [NSRC-1:0] ins_hit;

    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            ins_hit[s] = tag_seen(ins_tag[s*TAG_W +: TAG_W], wb_valid, wb_tag);
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic                 v_q;
        logic [NSRC-1:0]      rdy_q;
        logic [TAG_W-1:0]     tag_q [NSRC];
        port_mask_t           mask_q;
        logic [ID_W-1:0]      id_q;
        logic [NSRC-1:0]      hit;

        always_comb begin
            for (int s = 0; s < NSRC; s++) begin
                hit[s] = tag_seen(tag_q[s], wb_valid, wb_tag);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q   <= 1'b0;
                rdy_q <= '0;
            end else if (alloc_oh[e]) begin
                v_q    <= 1'b1;
                rdy_q  <= ins_rdy | ins_hit;
                mask_q <= ins_mask;
                id_q   <= ins_id;
                for (int s = 0; s < NSRC; s++) begin
                    tag_q[s] <= ins_tag[s*TAG_W +: TAG_W];
                end
            end else begin
                if (retire[e]) v_q <= 1'b0;
                rdy_q <= rdy_q | hit;
            end
        end

        assign valid_o[e] = v_q;
        assign ready_o[e] = v_q & (&rdy_q);
        assign mask_o[e]  = mask_q;
        assign id_o[e]    = id_q;
    end

endmodule

// File: rtl/sched_age_matrix.sv
module sched_age_matrix #(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] alloc_oh,
    input  logic [DEPTH-1:0] valid,
    // older_o[i][j] set: entry j was inserted before entry i
    output logic [DEPTH-1:0] older_o [DEPTH]
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        localparam logic [DEPTH-1:0] SELF = DEPTH'(1) << i;
        logic [DEPTH-1:0] row_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
            end else if (alloc_oh[i]) begin
                row_q <= valid & ~SELF;
            end else begin
                row_q <= row_q & ~alloc_oh;
            end
        end

        assign older_o[i] = row_q;
    end

endmodule

// File: rtl/sched_port_pick.sv
module sched_port_pick
    import sched_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0]     ready_i,
    input  port_mask_t           mask_i   [DEPTH],
    input  logic [DEPTH-1:0]     older_i  [DEPTH],
    input  logic [NUM_PORTS-1:0] port_busy,
    output logic [DEPTH-1:0]     grant_o  [NUM_PORTS]
);

    logic [DEPTH-1:0] avail [NUM_PORTS];

    assign avail[0] = ready_i;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [DEPTH-1:0] cap_p;
        logic [DEPTH-1:0] cand_p;
        logic [DEPTH-1:0] gnt_p;

        always_comb begin
            for (int e = 0; e < DEPTH; e++) cap_p[e] = mask_i[e][p];
        end

        assign cand_p = avail[p] & cap_p & {DEPTH{~port_busy[p]}};

        always_comb begin
            for (int i = 0; i < DEPTH; i++) begin
                gnt_p[i] = cand_p[i] & ~(|(cand_p & older_i[i]));
            end
        end

        assign grant_o[p] = gnt_p;

        if (p < NUM_PORTS - 1) begin : g_chain
            assign avail[p+1] = avail[p] & ~gnt_p;
        end
    end

endmodule

// File: rtl/issue_sched.sv
module issue_sched
    import sched_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int TAG_W    = 6,
    parameter int ID_W     = 8,
    parameter int NSRC     = 2,
    parameter int WB_LANES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ins_valid,
    output logic                      ins_ready,
    input  logic [2:0]                ins_class,
    input  logic [NSRC*TAG_W-1:0]     ins_src_tag,
    input  logic [NSRC-1:0]           ins_src_rdy,
    input  logic [ID_W-1:0]           ins_id,
    input  logic [WB_LANES-1:0]       wb_valid,
    input  logic [WB_LANES*TAG_W-1:0] wb_tag,
    input  logic [NUM_PORTS-1:0]      port_busy,
    output logic [NUM_PORTS-1:0]      iss_valid,
    output logic [NUM_PORTS*ID_W-1:0] iss_id
);

    localparam logic [DEPTH-1:0] ONE = DEPTH'(1);

    logic [DEPTH-1:0] ent_valid;
    logic [DEPTH-1:0] ent_ready;
    logic [DEPTH-1:0] free_vec;
    logic [DEPTH-1:0] alloc_oh;
    logic [DEPTH-1:0] retire;
    port_mask_t       ent_mask [DEPTH];
    logic [ID_W-1:0]  ent_id   [DEPTH];
    logic [DEPTH-1:0] older    [DEPTH];
    logic [DEPTH-1:0] grant    [NUM_PORTS];
    port_mask_t       ins_mask;

    assign free_vec  = ~ent_valid;
    assign ins_ready = |free_vec;
    assign alloc_oh  = (ins_valid && ins_ready) ? (free_vec & (~free_vec + ONE)) : '0;
    assign ins_mask  = class_ports(uop_class_e'(ins_class));

    sched_entry_array #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .ID_W(ID_W),
        .NSRC(NSRC), .WB_LANES(WB_LANES)
    ) u_entries (
        .clk      (clk),
        .rst      (rst),
        .alloc_oh (alloc_oh),
        .retire   (retire),
        .ins_mask (ins_mask),
        .ins_tag  (ins_src_tag),
        .ins_rdy  (ins_src_rdy),
        .ins_id   (ins_id),
        .wb_valid (wb_valid),
        .wb_tag   (wb_tag),
        .valid_o  (ent_valid),
        .ready_o  (ent_ready),
        .mask_o   (ent_mask),
        .id_o     (ent_id)
    );

    sched_age_matrix #(.DEPTH(DEPTH)) u_age (
        .clk      (clk),
        .rst      (rst),
        .alloc_oh (alloc_oh),
        .valid    (ent_valid),
        .older_o  (older)
    );

    sched_port_pick #(.DEPTH(DEPTH)) u_pick (
        .ready_i   (ent_ready),
        .mask_i    (ent_mask),
        .older_i   (older),
        .port_busy (port_busy),
        .grant_o   (grant)
    );

    always_comb begin
        retire = '0;
        for (int p = 0; p < NUM_PORTS; p++) retire = retire | grant[p];
    end

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            logic [ID_W-1:0] sel;
            sel = '0;
            for (int e = 0; e < DEPTH; e++) begin
                if (grant[p][e]) sel = sel | ent_id[e];
            end
            iss_valid[p]                = |grant[p];
            iss_id[p*ID_W +: ID_W]      = sel;
        end
    end

endmodule

// File: rtl/issue_sched_chk.sv
module issue_sched_chk
    import sched_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ins_valid,
    input logic                 ins_ready,
    input logic [NUM_PORTS-1:0] port_busy,
    input logic [NUM_PORTS-1:0] iss_valid,
    input logic [DEPTH-1:0]     ent_valid,
    input logic [DEPTH-1:0]     ent_ready,
    input logic [DEPTH-1:0]     grant [NUM_PORTS]
);

    logic [NUM_PORTS-1:0] col [DEPTH];

    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            for (int p = 0; p < NUM_PORTS; p++) col[e][p] = grant[p][e];
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (iss_valid == '0 && ins_ready));

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_ready) |=> ($countones(ent_valid) <= $past($countones(ent_valid))));

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent_chk
        // R7
        single_port_chk: assert property (@(posedge clk) disable iff (rst)
            $countones(col[e]) <= 1);

        // R3
        issue_ready_chk: assert property (@(posedge clk) disable iff (rst)
            (|col[e]) |-> (ent_valid[e] && ent_ready[e]));

        // R8
        leave_after_issue_chk: assert property (@(posedge clk) disable iff (rst)
            (|col[e]) |=> !ent_valid[e]);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        // R5
        busy_port_idle_chk: assert property (@(posedge clk) disable iff (rst)
            port_busy[p] |-> !iss_valid[p]);
    end

endmodule

bind issue_sched issue_sched_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .port_busy (port_busy),
    .iss_valid (iss_valid),
    .ent_valid (ent_valid),
    .ent_ready (ent_ready),
    .grant     (grant)
);

// File: tb/tb_issue_sched.sv
module tb_issue_sched;
    import sched_pkg::*;

    localparam int DEPTH = 16;
    localparam int TAG_W = 6;
    localparam int ID_W  = 8;
    localparam int NSRC  = 2;
    localparam int WBL   = 2;
    localparam int NP    = NUM_PORTS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic                   ins_valid;
    logic                   ins_ready;
    logic [2:0]             ins_class;
    logic [NSRC*TAG_W-1:0]  ins_src_tag;
    logic [NSRC-1:0]        ins_src_rdy;
    logic [ID_W-1:0]        ins_id;
    logic [WBL-1:0]         wb_valid;
    logic [WBL*TAG_W-1:0]   wb_tag;
    logic [NP-1:0]          port_busy;
    logic [NP-1:0]          iss_valid;
    logic [NP*ID_W-1:0]     iss_id;

    issue_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ID_W(ID_W), .NSRC(NSRC), .WB_LANES(WBL)) dut (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_class(ins_class), .ins_src_tag(ins_src_tag), .ins_src_rdy(ins_src_rdy),
        .ins_id(ins_id), .wb_valid(wb_valid), .wb_tag(wb_tag), .port_busy(port_busy),
        .iss_valid(iss_valid), .iss_id(iss_id)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model: slots are the bench's own, age is a sequence number
    bit              mv  [DEPTH];
    int unsigned     ms  [DEPTH];
    logic [NP-1:0]   mm  [DEPTH];
    logic [TAG_W-1:0] mt [DEPTH][NSRC];
    bit              mr  [DEPTH][NSRC];
    logic [ID_W-1:0] mid [DEPTH];
    int unsigned     seq = 0;
    int              mcount = 0;
    logic [NP-1:0]   ev;
    logic [ID_W-1:0] eid [NP];
    int              eslot [NP];
    logic [ID_W-1:0] nid = 8'd1;

    function automatic logic [NP-1:0] spec_mask(input logic [2:0] c);
        case (c)
            3'd1: return 10'b0001000001;
            3'd2: return 10'b0000000001;
            3'd3: return 10'b0000001100;
            3'd4: return 10'b0110000000;
            3'd5: return 10'b1000010000;
            default: return 10'b0001100011;
        endcase
    endfunction

    function automatic bit bcast(input logic [TAG_W-1:0] t);
        for (int l = 0; l < WBL; l++)
            if (wb_valid[l] && wb_tag[l*TAG_W +: TAG_W] == t) return 1'b1;
        return 1'b0;
    endfunction

    task automatic compute_expect();
        bit av [DEPTH];
        for (int e = 0; e < DEPTH; e++) av[e] = mv[e] && mr[e][0] && mr[e][1];
        for (int p = 0; p < NP; p++) begin
            int best;
            best = -1;
            ev[p] = 1'b0; eid[p] = '0; eslot[p] = -1;
            if (!port_busy[p]) begin
                for (int e = 0; e < DEPTH; e++) begin
                    if (av[e] && mm[e][p]) begin
                        if (best < 0) best = e;
                        else if (ms[e] < ms[best]) best = e;
                    end
                end
            end
            if (best >= 0) begin
                ev[p] = 1'b1; eid[p] = mid[best]; eslot[p] = best; av[best] = 1'b0;
            end
        end
    endtask

    task automatic idle();
        ins_valid = 1'b0; ins_class = '0; ins_src_tag = '0; ins_src_rdy = '0; ins_id = '0;
        wb_valid = '0; wb_tag = '0; port_busy = '0;
    endtask

    task automatic put(input logic [2:0] c, input logic [TAG_W-1:0] t0, input bit r0,
                       input logic [TAG_W-1:0] t1, input bit r1);
        ins_valid = 1'b1; ins_class = c;
        ins_src_tag = {t1, t0}; ins_src_rdy = {r1, r0};
        ins_id = nid; nid = nid + 8'd1;
    endtask

    // compare this cycle against the model, then advance one clock
    task automatic step();
        #1;
        compute_expect();
        chk(iss_valid == ev, "R6 R7 per-port issue vector", 64'(iss_valid), 64'(ev));
        for (int p = 0; p < NP; p++)
            if (ev[p]) chk(iss_id[p*ID_W +: ID_W] == eid[p], "R6 oldest id on port",
                           64'(iss_id[p*ID_W +: ID_W]), 64'(eid[p]));
        chk(ins_ready == (mcount < DEPTH), "R9 ins_ready", 64'(ins_ready), 64'(mcount < DEPTH));
        @(posedge clk);
        begin
            bool_upd();
        end
        @(negedge clk);
    endtask

    task automatic bool_upd();
        bit accept;
        accept = ins_valid && (mcount < DEPTH);
        for (int p = 0; p < NP; p++) if (ev[p]) mv[eslot[p]] = 1'b0;
        for (int e = 0; e < DEPTH; e++)
            if (mv[e]) for (int s = 0; s < NSRC; s++) if (bcast(mt[e][s])) mr[e][s] = 1'b1;
        if (accept) begin
            for (int e = 0; e < DEPTH; e++) begin
                if (!mv[e]) begin
                    mv[e] = 1'b1; ms[e] = seq; seq++;
                    mm[e] = spec_mask(ins_class); mid[e] = ins_id;
                    for (int s = 0; s < NSRC; s++) begin
                        mt[e][s] = ins_src_tag[s*TAG_W +: TAG_W];
                        mr[e][s] = ins_src_rdy[s] || bcast(ins_src_tag[s*TAG_W +: TAG_W]);
                    end
                    break;
                end
            end
        end
        mcount = 0;
        for (int e = 0; e < DEPTH; e++) if (mv[e]) mcount++;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog (run did not complete) actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [ID_W-1:0] first_ld;
        void'($urandom(32'd1234));
        idle();
        for (int e = 0; e < DEPTH; e++) mv[e] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(iss_valid == '0, "R1 no issue in reset", 64'(iss_valid), 64'd0);
        rst = 1'b0;
        #1;
        chk(iss_valid == '0 && ins_ready, "R1 quiet after reset", 64'({iss_valid, ins_ready}), 64'd1);

        // R2 and R10: each class alone lands on its first allowed port one cycle after insertion
        for (int c = 0; c < 6; c++) begin
            logic [NP-1:0] want;
            want = (c == 3) ? 10'b0000000100 : (c == 4) ? 10'b0010000000 :
                   (c == 5) ? 10'b0000010000 : 10'b0000000001;
            idle(); put(3'(c), 6'd1, 1'b1, 6'd2, 1'b1);
            step();
            idle(); #1;
            chk(iss_valid == want, "R2 R10 class to port", 64'(iss_valid), 64'(want));
            step();
        end

        // R5 R6: two loads held by busy ports, then released together
        idle(); port_busy = '1; put(3'd3, 6'd0, 1'b1, 6'd0, 1'b1); first_ld = ins_id; step();
        idle(); port_busy = '1; put(3'd3, 6'd0, 1'b1, 6'd0, 1'b1); step();
        idle(); port_busy = '1; #1;
        chk(iss_valid == '0, "R5 busy ports hold loads", 64'(iss_valid), 64'd0);
        step();
        idle(); #1;
        chk(iss_valid == 10'b0000001100 && iss_id[2*ID_W +: ID_W] == first_ld,
            "R6 older load on port 2", 64'(iss_id[2*ID_W +: ID_W]), 64'(first_ld));
        step();

        // R5: divide waits on busy port 0; an integer op with port 0 busy moves to port 1
        idle(); port_busy = 10'b1; put(3'd2, 6'd0, 1'b1, 6'd0, 1'b1); step();
        idle(); port_busy = 10'b1; put(3'd0, 6'd0, 1'b1, 6'd0, 1'b1); step();
        idle(); port_busy = 10'b1; #1;
        chk(iss_valid == 10'b0000000010, "R5 int op rerouted, divide waits", 64'(iss_valid), 64'd2);
        step();
        idle(); #1;
        chk(iss_valid == 10'b1, "R5 divide after release", 64'(iss_valid), 64'd1);
        step();

        // R3: wakeup by broadcast, eligible one cycle later
        idle(); put(3'd0, 6'd5, 1'b0, 6'd3, 1'b1); step();
        idle(); step(); idle(); #1;
        chk(iss_valid == '0, "R3 waits on source", 64'(iss_valid), 64'd0);
        step();
        idle(); wb_valid = 2'b10; wb_tag = {6'd5, 6'd0}; #1;
        chk(iss_valid == '0, "R3 not eligible in broadcast cycle", 64'(iss_valid), 64'd0);
        step();
        idle(); #1;
        chk(iss_valid == 10'b1, "R3 eligible after broadcast", 64'(iss_valid), 64'd1);
        step();

        // R4: capture of a broadcast during insertion
        idle(); put(3'd1, 6'd9, 1'b0, 6'd9, 1'b0); wb_valid = 2'b01; wb_tag = {6'd0, 6'd9}; step();
        idle(); #1;
        chk(iss_valid == 10'b1, "R4 capture at insert", 64'(iss_valid), 64'd1);
        step();

        // R9 R8: fill, drop an extra insert, then wake everything at once
        for (int k = 0; k < DEPTH; k++) begin
            idle(); put(3'(k % 6), 6'd20, 1'b0, 6'd21, 1'b1); step();
        end
        idle(); #1;
        chk(!ins_ready, "R9 full", 64'(ins_ready), 64'd0);
        put(3'd0, 6'd0, 1'b1, 6'd0, 1'b1); step();
        idle(); #1;
        chk(iss_valid == '0, "R9 dropped insert does not issue", 64'(iss_valid), 64'd0);
        step();
        idle(); wb_valid = 2'b01; wb_tag = {6'd0, 6'd20}; step();
        idle(); #1;
        chk(iss_valid == 10'b1111111111, "R8 ten issues in one cycle", 64'(iss_valid), 64'h3ff);
        repeat (6) begin idle(); step(); end
        chk(mcount == 0 && ins_ready, "R8 drained", 64'(mcount), 64'd0);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            idle();
            if ($urandom_range(99) < 70)
                put(3'($urandom_range(7)), 6'($urandom_range(15)), 1'($urandom_range(1)),
                    6'($urandom_range(15)), 1'($urandom_range(1)));
            for (int l = 0; l < WBL; l++) begin
                wb_valid[l] = 1'($urandom_range(1));
                wb_tag[l*TAG_W +: TAG_W] = 6'($urandom_range(15));
            end
            for (int p = 0; p < NP; p++) port_busy[p] = ($urandom_range(99) < 20);
            step();
        end

        // drain: broadcast every tag, ports free
        for (int t = 0; t < 16; t++) begin
            idle(); wb_valid = 2'b11; wb_tag = {6'(t), 6'(15 - t)}; step();
        end
        repeat (8) begin idle(); step(); end
        chk(mcount == 0, "R3 all entries eventually issue", 64'(mcount), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule